// File: doc/BRIEF.md
# Banked internal data RAM

This block is the 256-byte on-chip data memory of an 8-bit microcontroller core. It gives the core a byte operand port with direct or indirect addressing, a working-register operand port that reaches R0..R7 of the bank chosen by a 2-bit bank-select input, and a single-bit operand port into the 16-byte bit-addressable window that starts at byte 20h. All three read ports are combinational. One synchronous write port takes a byte in one of four modes, or a single bit. A bit write changes only the addressed bit and leaves the rest of its byte unchanged.

The lower 128 bytes are shared by every access style. The upper 128 bytes are reached only by indirect addressing. A direct access to 80h..FFh belongs to the special-function space, which is decoded elsewhere. For such an access the block raises a select output and does not touch its own storage. Data storage has no reset. The reset input only blocks writes while it is held, and the contents stay undefined until the core writes them.

The write decode works as a small state selector. The write mode is an enumerated kind with four values: WM_DIRECT, WM_INDIRECT, WM_REG and WM_BIT. One unique case picks the target byte and data for each mode. There is no sequencing state, so there are no transitions: every write completes at the clock edge where it is presented.

Top module: `iram_banked`

## Requirements
- R1: reg_data equals the byte at address bank_sel*8 + rd_reg. Bank-select code 0 picks bytes 00h..07h, 1 picks 08h..0Fh, 2 picks 10h..17h and 3 picks 18h..1Fh.
- R2: A write with wr_mode = 2 (register) stores wr_data at bank_sel*8 + wr_addr[2:0] and ignores wr_addr[7:3].
- R3: bit_data equals bit rd_bit_addr[2:0] of byte 20h + rd_bit_addr[6:3], so bit address 00h..7Fh covers bytes 20h..2Fh with bit 0 as the least significant.
- R4: A write with wr_mode = 3 (bit) and wr_addr[7] = 0 sets bit wr_addr[2:0] of byte 20h + wr_addr[6:3] to wr_bit and leaves the other seven bits of that byte unchanged.
- R5: A direct byte read (rd_indirect = 0) of 80h..FFh raises rd_sfr_sel and returns 00h on rd_data. A direct write (wr_mode = 0) to 80h..FFh raises wr_sfr_sel in the same cycle and changes no RAM byte, including the upper byte at the same address.
- R6: An indirect read (rd_indirect = 1) or write (wr_mode = 1) reaches every one of the 256 bytes and never raises rd_sfr_sel.
- R7: A read of the location being written in the same cycle returns the old value, and the new value appears from the next cycle.
- R8: Below 80h, direct and indirect addressing reach the same byte, and scratch bytes 30h..7Fh hold whatever is last written.
- R9: A bit write with wr_addr[7] = 1 raises wr_sfr_sel and changes no RAM byte.
- R10: While rst_n is low, no write changes RAM and wr_sfr_sel stays low. Reset does not clear stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes only |
| bank_sel | input | 2 | Working-register bank for both register ports |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| wr_addr | input | 8 | Byte address, register number in [2:0], or bit address |
| wr_data | input | 8 | Byte to write |
| wr_bit | input | 1 | Bit value for bit writes |
| rd_addr | input | 8 | Byte read address |
| rd_indirect | input | 1 | 1 selects indirect addressing for the byte read |
| rd_reg | input | 3 | Register number for the register read |
| rd_bit_addr | input | 7 | Bit address for the bit read |
| rd_data | output | 8 | Byte read result, 00h for special-function accesses |
| rd_sfr_sel | output | 1 | Byte read belongs to the special-function space |
| reg_data | output | 8 | Register read result |
| bit_data | output | 1 | Bit read result |
| wr_sfr_sel | output | 1 | Current write belongs to the special-function space |

## Verification
A wrong bank or bit mapping stores a byte in the wrong place. The error then shows on whichever read port next looks at that place or at the place it should have gone. The bench reads all three ports against a behavioural byte image on every cycle, so the error appears within one cycle of the first overlapping read. A broken bit merge corrupts neighbouring bits, and the next direct read of that byte exposes it. A wrong special-function decode shows at once on rd_sfr_sel or wr_sfr_sel. It also shows on the next indirect read of the upper byte it should not have written.

// File: rtl/iram_pkg.sv
package iram_pkg;
    typedef enum logic [1:0] {
        WM_DIRECT   = 2'd0,
        WM_INDIRECT = 2'd1,
        WM_REG      = 2'd2,
        WM_BIT      = 2'd3
    } wmode_e;
endpackage

// File: rtl/iram_bank_map.sv
module iram_bank_map #(
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  rnum,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam int PAD_W = ADDR_W - BANK_W - REG_W;

    // bank*regs_per_bank + register number
    assign byte_addr = {{PAD_W{1'b0}}, bank, rnum};
endmodule

// File: rtl/iram_bit_map.sv
module iram_bit_map #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BIT_BASE = 32,
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int BA_W    = ADDR_W - 1
) (
    input  logic [BA_W-1:0]   bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam int OFS_W = BA_W - IDX_W;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BIT_BASE);

    assign byte_addr = BASE + {{(ADDR_W-OFS_W){1'b0}}, bit_addr[BA_W-1:IDX_W]};
    assign bit_idx   = bit_addr[IDX_W-1:0];
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_byte,
    input  logic [IDX_W-1:0]  idx,
    input  logic              val,
    output logic [DATA_W-1:0] new_byte
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign new_byte[i] = (idx == IDX_W'(i)) ? val : old_byte[i];
    end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NRD    = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]  raddr,
    output logic [NRD-1:0][DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // asynchronous reads: a same-cycle write is seen only after the edge
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/iram_banked.sv
module iram_banked
    import iram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int BANK_W     = 2,
    parameter int REG_W      = 3,
    parameter int BIT_BASE   = 32,
    localparam int BA_W      = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_indirect,
    input  logic [REG_W-1:0]  rd_reg,
    input  logic [BA_W-1:0]   rd_bit_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sfr_sel,
    output logic [DATA_W-1:0] reg_data,
    output logic              bit_data,
    output logic              wr_sfr_sel
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int NRD   = 4;
    localparam int P_BYTE = 0, P_REG = 1, P_BIT = 2, P_RMW = 3;

    logic [ADDR_W-1:0] reg_rd_byte, reg_wr_byte, bit_rd_byte, bit_wr_byte;
    logic [IDX_W-1:0]  bit_rd_idx, bit_wr_idx;
    logic [NRD-1:0][ADDR_W-1:0] st_addr;
    logic [NRD-1:0][DATA_W-1:0] st_q;
    logic [DATA_W-1:0] merged;
    logic              st_we;
    logic [ADDR_W-1:0] st_waddr;
    logic [DATA_W-1:0] st_wdata;
    logic              upper;

    iram_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_rd_bank (
        .bank(bank_sel), .rnum(rd_reg), .byte_addr(reg_rd_byte)
    );
    iram_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_wr_bank (
        .bank(bank_sel), .rnum(wr_addr[REG_W-1:0]), .byte_addr(reg_wr_byte)
    );
    iram_bit_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE)) u_rd_bit (
        .bit_addr(rd_bit_addr), .byte_addr(bit_rd_byte), .bit_idx(bit_rd_idx)
    );
    iram_bit_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE)) u_wr_bit (
        .bit_addr(wr_addr[BA_W-1:0]), .byte_addr(bit_wr_byte), .bit_idx(bit_wr_idx)
    );

    assign st_addr[P_BYTE] = rd_addr;
    assign st_addr[P_REG]  = reg_rd_byte;
    assign st_addr[P_BIT]  = bit_rd_byte;
    assign st_addr[P_RMW]  = bit_wr_byte;

    iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .raddr(st_addr), .rdata(st_q)
    );

    iram_bit_merge #(.DATA_W(DATA_W)) u_merge (
        .old_byte(st_q[P_RMW]), .idx(bit_wr_idx), .val(wr_bit), .new_byte(merged)
    );

    // read side
    assign rd_sfr_sel = !rd_indirect && rd_addr[ADDR_W-1];
    assign rd_data    = rd_sfr_sel ? '0 : st_q[P_BYTE];
    assign reg_data   = st_q[P_REG];
    assign bit_data   = st_q[P_BIT][bit_rd_idx];

    // write side: one selector per mode
    assign upper = wr_addr[ADDR_W-1];

    always_comb begin
        st_we      = 1'b0;
        st_waddr   = wr_addr;
        st_wdata   = wr_data;
        wr_sfr_sel = 1'b0;
        if (wr_en && rst_n) begin
            unique case (wmode_e'(wr_mode))
                WM_DIRECT: begin
                    st_we      = !upper;
                    wr_sfr_sel = upper;
                end
                WM_INDIRECT: begin
                    st_we = 1'b1;
                end
                WM_REG: begin
                    st_we    = 1'b1;
                    st_waddr = reg_wr_byte;
                end
                WM_BIT: begin
                    st_we      = !upper;
                    wr_sfr_sel = upper;
                    st_waddr   = bit_wr_byte;
                    st_wdata   = merged;
                end
            endcase
        end
    end
endmodule

// File: rtl/iram_checker.sv
module iram_checker
    import iram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    localparam int BA_W  = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic              wr_en,
    input logic [1:0]        wr_mode,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_bit,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_indirect,
    input logic [REG_W-1:0]  rd_reg,
    input logic [BA_W-1:0]   rd_bit_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_sfr_sel,
    input logic [DATA_W-1:0] reg_data,
    input logic              bit_data,
    input logic              wr_sfr_sel
);
    AST_DIRECT_HIGH_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_indirect && rd_addr[ADDR_W-1]) |-> (rd_sfr_sel && rd_data == '0)); // R5

    AST_DIRECT_WR_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == WM_DIRECT && wr_addr[ADDR_W-1]) |-> wr_sfr_sel); // R5

    AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_indirect |-> !rd_sfr_sel); // R6

    AST_INDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == WM_INDIRECT) |=>
        ((rd_indirect && rd_addr == $past(wr_addr)) -> rd_data == $past(wr_data))); // R7

    AST_REG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == WM_REG) |=>
        ((rd_reg == $past(wr_addr[REG_W-1:0]) && bank_sel == $past(bank_sel))
         -> reg_data == $past(wr_data))); // R2

    AST_BIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == WM_BIT && !wr_addr[ADDR_W-1]) |=>
        ((rd_bit_addr == $past(wr_addr[BA_W-1:0])) -> bit_data == $past(wr_bit))); // R4

    AST_BIT_HIGH_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == WM_BIT && wr_addr[ADDR_W-1]) |-> wr_sfr_sel); // R9

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!wr_sfr_sel); // R10
        end
    end
endmodule

bind iram_banked iram_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_W(REG_W)
) u_iram_checker (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en),
    .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_indirect(rd_indirect), .rd_reg(rd_reg),
    .rd_bit_addr(rd_bit_addr), .rd_data(rd_data), .rd_sfr_sel(rd_sfr_sel),
    .reg_data(reg_data), .bit_data(bit_data), .wr_sfr_sel(wr_sfr_sel)
);

// File: tb/test_iram_banked.sv
module test_iram_banked;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = '0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_bit = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       rd_indirect = 1'b0;
    logic [2:0] rd_reg = '0;
    logic [6:0] rd_bit_addr = '0;
    logic [7:0] rd_data, reg_data;
    logic       rd_sfr_sel, bit_data, wr_sfr_sel;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    string scen = "reset";
    int  model [256];
    bit  valid [256];

    always #4 clk = ~clk;

    iram_banked i_iram_banked (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en),
        .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bit(wr_bit),
        .rd_addr(rd_addr), .rd_indirect(rd_indirect), .rd_reg(rd_reg),
        .rd_bit_addr(rd_bit_addr), .rd_data(rd_data), .rd_sfr_sel(rd_sfr_sel),
        .reg_data(reg_data), .bit_data(bit_data), .wr_sfr_sel(wr_sfr_sel)
    );

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%0h expected=%0h", scen, what, act, exp);
        end
    endtask

    // compare all ports against the byte image, then apply the write at the edge
    task automatic cyc();
        int ra, ri, bb;
        bit sfr_rd, sfr_wr;
        #1;
        ra = int'(rd_addr);
        sfr_rd = !rd_indirect && rd_addr[7];
        chk("R5 R6 rd_sfr_sel", int'(rd_sfr_sel), int'(sfr_rd));
        if (sfr_rd) chk("R5 rd_data", int'(rd_data), 0);
        else if (valid[ra]) chk(rd_indirect ? "R6 rd_data" : "R8 rd_data", int'(rd_data), model[ra]);
        ri = int'(bank_sel) * 8 + int'(rd_reg);
        if (valid[ri]) chk("R1 reg_data", int'(reg_data), model[ri]);
        bb = 32 + int'(rd_bit_addr >> 3);
        if (valid[bb]) chk("R3 bit_data", int'(bit_data), (model[bb] >> rd_bit_addr[2:0]) & 1);
        sfr_wr = rst_n && wr_en && (wr_mode == 2'd0 || wr_mode == 2'd3) && wr_addr[7];
        chk("R5 R9 R10 wr_sfr_sel", int'(wr_sfr_sel), int'(sfr_wr));
        @(posedge clk);
        if (rst_n && wr_en) begin
            case (wr_mode)
                2'd0: if (!wr_addr[7]) begin model[wr_addr] = int'(wr_data); valid[wr_addr] = 1; end
                2'd1: begin model[wr_addr] = int'(wr_data); valid[wr_addr] = 1; end
                2'd2: begin
                    ri = int'(bank_sel) * 8 + int'(wr_addr[2:0]);
                    model[ri] = int'(wr_data); valid[ri] = 1;
                end
                default: if (!wr_addr[7]) begin
                    bb = 32 + int'(wr_addr[6:3]);
                    if (wr_bit) model[bb] = model[bb] | (1 << wr_addr[2:0]);
                    else        model[bb] = model[bb] & ~(1 << wr_addr[2:0]);
                end
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] m, logic [7:0] a, logic [7:0] d, logic b);
        wr_en = 1'b1; wr_mode = m; wr_addr = a; wr_data = d; wr_bit = b;
    endtask

    task automatic rd(logic ind, logic [7:0] a, logic [2:0] r, logic [6:0] ba);
        rd_indirect = ind; rd_addr = a; rd_reg = r; rd_bit_addr = ba;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL [watchdog] run did not complete actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin model[i] = 0; valid[i] = 0; end
        @(negedge clk);
        // R10: writes in reset are blocked and raise no select
        scen = "R10 reset";
        wr(2'd0, 8'h90, 8'h11, 1'b0); rd(1'b0, 8'h90, 3'd0, 7'd0);
        cyc(); cyc();
        rst_n = 1'b1;

        // R6 R7: fill every byte indirectly, reading the byte being written
        scen = "R6 R7 fill";
        for (int i = 0; i < 256; i++) begin
            wr(2'd1, 8'(i), 8'(i * 7 + 3), 1'b0);
            rd(1'b1, 8'(i), 3'd0, 7'd0);
            cyc();
        end
        // R7: same cycle old value, next cycle new value
        scen = "R7 read during write";
        wr(2'd0, 8'h45, 8'hA5, 1'b0); rd(1'b0, 8'h45, 3'd0, 7'd0); cyc();
        wr_en = 1'b0; cyc();

        // R1 R2: every register of every bank
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) begin
                scen = "R1 R2 banks";
                bank_sel = 2'(b);
                wr(2'd2, {5'b10101, 3'(r)}, 8'(b * 16 + r + 8'h40), 1'b0);
                rd(1'b0, 8'(b * 8 + r), 3'(r), 7'd0);
                cyc();
                wr_en = 1'b0; cyc();
            end
        end

        // R3 R4: bit writes touch one bit only
        scen = "R3 R4 bit write";
        wr(2'd3, 8'h53, 8'h00, 1'b1); rd(1'b0, 8'h2A, 3'd0, 7'h53); cyc();
        wr(2'd3, 8'h51, 8'hFF, 1'b0); cyc();
        wr_en = 1'b0; rd(1'b0, 8'h2A, 3'd0, 7'h51); cyc();
        wr(2'd3, 8'h00, 8'h00, 1'b0); rd(1'b0, 8'h20, 3'd0, 7'h00); cyc();
        wr(2'd3, 8'h7F, 8'h00, 1'b1); rd(1'b0, 8'h2F, 3'd0, 7'h7F); cyc();
        wr_en = 1'b0; cyc();

        // R5: direct high writes go to the special-function space
        scen = "R5 direct high";
        wr(2'd0, 8'hC0, 8'h5A, 1'b0); rd(1'b0, 8'hC0, 3'd0, 7'd0); cyc();
        wr_en = 1'b0; rd(1'b1, 8'hC0, 3'd0, 7'd0); cyc();

        // R9: bit write above 7Fh leaves the bit area alone
        scen = "R9 bit high";
        wr(2'd3, 8'h85, 8'h00, ~model[32][5] ? 1'b1 : 1'b0); rd(1'b0, 8'h20, 3'd0, 7'h05); cyc();
        wr_en = 1'b0; cyc();

        // R8: scratch byte via direct write, indirect read
        scen = "R8 scratch";
        wr(2'd0, 8'h7F, 8'h3C, 1'b0); cyc();
        wr_en = 1'b0; rd(1'b1, 8'h7F, 3'd0, 7'd0); cyc();

        // R10: reset again, contents kept, write blocked
        scen = "R10 reset hold";
        rst_n = 1'b0;
        wr(2'd1, 8'h10, 8'hEE, 1'b0); rd(1'b1, 8'h10, 3'd0, 7'd0); cyc();
        rst_n = 1'b1; wr_en = 1'b0; cyc();

        scen = "random";
        for (int k = 0; k < 3000; k++) begin
            bank_sel = 2'($urandom);
            wr_en = 1'($urandom);
            wr_mode = 2'($urandom);
            wr_addr = 8'($urandom);
            wr_data = 8'($urandom);
            wr_bit = 1'($urandom);
            rd_indirect = 1'($urandom);
            rd_addr = (k % 3 == 0) ? wr_addr : 8'($urandom);
            rd_reg = 3'($urandom);
            rd_bit_addr = 7'($urandom);
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule